// File: doc/BRIEF.md
# Windowed Overload Event Detector

This block watches a stream of samples and, for each sample, decides whether it is an overload. A sample is an overload when an external per-sample flag is set or when its magnitude lies strictly above a programmable magnitude limit. The stream is divided into back-to-back, non-overlapping windows. The window length comes from a 3-bit size code. The block counts overload samples inside the current window. When that count reaches a programmable trigger count, it raises a one-cycle event pulse. The event is meant to drive the threshold-exceeded counters of an automatic gain control loop.

The size code does not map linearly to a length, and one code value is illegal. The block reports that code on a configuration-invalid output and produces no events while it is selected. A single enable input switches the detector on and off. The intended power-on configuration is size code 1 with a trigger count of 1.

Top module: `ovld_window_det`

## Requirements
- R1: After reset, `ovl_event` and `cfg_invalid` are both 0.
- R2: The window length follows `win_code`: 3'b000 gives 1 sample, 3'b001 gives 4, 3'b010 gives 8, 3'b011 gives 12, 3'b100 gives 16, 3'b101 gives 24 and 3'b110 gives 32. Only samples with `sample_valid` high are counted toward the length.
- R3: An accepted overload sample that makes the window's overload count equal to `trig_count` raises `ovl_event` for exactly one cycle, in the cycle after that sample is presented.
- R4: At most one event is produced per window. The last sample of a window, which may itself fire the event, closes the window, and the next window starts with an overload count of zero.
- R5: A sample is an overload when `ovl_flag` is 1 or when `sample_mag` is strictly greater than `mag_limit`, compared as unsigned values. A magnitude equal to the limit is not an overload.
- R6: A cycle with `sample_valid` low neither advances the window nor changes the count, and it produces no event.
- R7: While `det_en` is 0, no event is produced and the window is restarted. The first valid sample after enable rises is sample 0 of a new window.
- R8: `win_code` = 3'b111 sets `cfg_invalid` to 1 in the following cycle and holds it there while the code stays. No event is produced while the code is selected, and the window is restarted. `cfg_invalid` is 0 in the cycle after any other code is applied.
- R9: A `trig_count` of 0, or a value larger than the window length, never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_en | input | 1 | Detector enable |
| sample_valid | input | 1 | Qualifies the current sample |
| ovl_flag | input | 1 | External per-sample overload flag |
| sample_mag | input | MAG_W | Raw sample magnitude, unsigned |
| mag_limit | input | MAG_W | Magnitude limit; overload when magnitude is above it |
| win_code | input | 3 | Window-size code |
| trig_count | input | CNT_W | Overload count that fires the event |
| ovl_event | output | 1 | One-cycle event pulse |
| cfg_invalid | output | 1 | Illegal window-size code selected |

## Verification
A position counter that slips would change the window length. The event would then land on the wrong sample or fire twice within a window's span, and this shows within one or two windows, so at most 64 valid samples. A count that fails to clear at a boundary makes an event fire early, or never fire, in the very next window. A count that advances on invalid or non-overload samples makes events fire on the wrong cycle within the first window that uses gaps. A wrong magnitude compare or a wrong code decode shows on the first sample or cycle that uses it.

// File: rtl/ovwd_pkg.sv
package ovwd_pkg;

    localparam int MAX_WIN = 32;
    localparam int POS_W   = $clog2(MAX_WIN);

    typedef logic [2:0] win_code_t;

    localparam win_code_t CODE_ILLEGAL = 3'b111;

    // Index of the final sample in a window for a given size code.
    function automatic logic [POS_W-1:0] win_last_idx(input win_code_t code);
        logic [POS_W:0] len;
        case (code)
            3'd0:    len = 6'd1;
            3'd1:    len = 6'd4;
            3'd2:    len = 6'd8;
            3'd3:    len = 6'd12;
            3'd4:    len = 6'd16;
            3'd5:    len = 6'd24;
            3'd6:    len = 6'd32;
            default: len = 6'd1;
        endcase
        return POS_W'(len - 6'd1);
    endfunction

endpackage

// File: rtl/ovwd_size_decode.sv
module ovwd_size_decode
    import ovwd_pkg::*;
(
    input  win_code_t        code_i,
    output logic [POS_W-1:0] last_idx_o,
    output logic             illegal_o
);

    always_comb begin
        illegal_o  = (code_i == CODE_ILLEGAL);
        last_idx_o = win_last_idx(code_i);
    end

endmodule

// File: rtl/ovwd_mag_compare.sv
module ovwd_mag_compare #(
    parameter int MAG_W = 12
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic [MAG_W-1:0] limit_i,
    input  logic             flag_i,
    output logic             ovl_o
);

    always_comb begin
        ovl_o = flag_i | (mag_i > limit_i);
    end

endmodule

// File: rtl/ovwd_window_ctr.sv
module ovwd_window_ctr
    import ovwd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             illegal_i,
    input  logic             valid_i,
    input  logic             ovl_i,
    input  logic [CNT_W-1:0] trig_i,
    input  logic [POS_W-1:0] last_idx_i,
    output logic             event_o,
    output logic             invalid_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic             evt;
        logic             bad;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc_d;

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        st_d.bad  = illegal_i;
        cnt_inc_d = st_q.cnt + {{(CNT_W-1){1'b0}}, ovl_i};

        if (!run_i) begin
            st_d.pos = '0;
            st_d.cnt = '0;
        end else if (valid_i) begin
            st_d.evt = ovl_i && (trig_i != '0) && (cnt_inc_d == trig_i);
            if (st_q.pos >= last_idx_i) begin
                st_d.pos = '0;
                st_d.cnt = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
                st_d.cnt = cnt_inc_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o   = st_q.evt;
    assign invalid_o = st_q.bad;

endmodule

// File: rtl/ovld_window_det.sv
module ovld_window_det
    import ovwd_pkg::*;
#(
    parameter int MAG_W = 12,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             sample_valid,
    input  logic             ovl_flag,
    input  logic [MAG_W-1:0] sample_mag,
    input  logic [MAG_W-1:0] mag_limit,
    input  logic [2:0]       win_code,
    input  logic [CNT_W-1:0] trig_count,
    output logic             ovl_event,
    output logic             cfg_invalid
);

    logic [POS_W-1:0] last_idx;
    logic             code_bad;
    logic             sample_ovl;
    logic             run;

    ovwd_size_decode u_decode (
        .code_i     (win_code),
        .last_idx_o (last_idx),
        .illegal_o  (code_bad)
    );

    ovwd_mag_compare #(.MAG_W(MAG_W)) u_compare (
        .mag_i   (sample_mag),
        .limit_i (mag_limit),
        .flag_i  (ovl_flag),
        .ovl_o   (sample_ovl)
    );

    assign run = det_en & ~code_bad;

    ovwd_window_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .illegal_i  (code_bad),
        .valid_i    (sample_valid),
        .ovl_i      (sample_ovl),
        .trig_i     (trig_count),
        .last_idx_i (last_idx),
        .event_o    (ovl_event),
        .invalid_o  (cfg_invalid)
    );

endmodule

// File: rtl/ovwd_checker.sv
module ovwd_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             sample_valid,
    input logic [2:0]       win_code,
    input logic [CNT_W-1:0] trig_count,
    input logic             ovl_event,
    input logic             cfg_invalid
);

    // R8: illegal code raises the flag one cycle later
    a_r8_flag_on_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (win_code == 3'b111) |=> cfg_invalid);

    // R8: legal code clears the flag one cycle later
    a_r8_flag_clear_on_good_code: assert property (@(posedge clk) disable iff (!rst_n)
        (win_code != 3'b111) |=> !cfg_invalid);

    // R8: no event while invalid is flagged
    a_r8_no_event_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !ovl_event);

    // R7: disabled detector produces no event
    a_r7_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !ovl_event);

    // R6: no event without a valid sample
    a_r6_no_event_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !ovl_event);

    // R9: zero trigger count never fires
    a_r9_zero_trigger_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_count == '0) |=> !ovl_event);

endmodule

bind ovld_window_det ovwd_checker #(.CNT_W(CNT_W)) u_ovwd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_en       (det_en),
    .sample_valid (sample_valid),
    .win_code     (win_code),
    .trig_count   (trig_count),
    .ovl_event    (ovl_event),
    .cfg_invalid  (cfg_invalid)
);

// File: tb/ovld_window_det_tb.sv
module ovld_window_det_tb_top;

    localparam int MAG_W = 12;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             det_en = 1'b0;
    logic             sample_valid = 1'b0;
    logic             ovl_flag = 1'b0;
    logic [MAG_W-1:0] sample_mag = '0;
    logic [MAG_W-1:0] mag_limit = 12'd100;
    logic [2:0]       win_code = 3'd1;
    logic [CNT_W-1:0] trig_count = 6'd1;
    logic             ovl_event;
    logic             cfg_invalid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference state
    int  m_pos = 0;
    int  m_cnt = 0;
    bit  exp_evt = 1'b0;
    bit  exp_bad = 1'b0;

    always #10 clk = ~clk;

    ovld_window_det #(.MAG_W(MAG_W), .CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .det_en       (det_en),
        .sample_valid (sample_valid),
        .ovl_flag     (ovl_flag),
        .sample_mag   (sample_mag),
        .mag_limit    (mag_limit),
        .win_code     (win_code),
        .trig_count   (trig_count),
        .ovl_event    (ovl_event),
        .cfg_invalid  (cfg_invalid)
    );

    function automatic int len_of(input int code);
        if (code == 0) return 1;
        if (code <= 4) return 4 * code;
        if (code == 5) return 24;
        return 32;
    endfunction

    task automatic check_bit(input string req, input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: check outputs of the previous cycle, then drive a new sample.
    task automatic step(input string req, input bit en, input int code, input int trig,
                        input bit vld, input bit flag, input int mag);
        bit ov;
        @(negedge clk);
        check_bit(req, "ovl_event", ovl_event, exp_evt);
        check_bit("R8", "cfg_invalid", cfg_invalid, exp_bad);
        det_en = en; win_code = 3'(code); trig_count = CNT_W'(trig);
        sample_valid = vld; ovl_flag = flag; sample_mag = MAG_W'(mag);
        exp_bad = (code == 7);
        exp_evt = 1'b0;
        if (!en || code == 7) begin
            m_pos = 0; m_cnt = 0;
        end else if (vld) begin
            ov = flag || (mag > int'(mag_limit));
            if (ov && trig != 0 && (m_cnt + 1) == trig) exp_evt = 1'b1;
            if (m_pos >= len_of(code) - 1) begin
                m_pos = 0; m_cnt = 0;
            end else begin
                m_pos++; m_cnt += int'(ov);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_bit("R1", "ovl_event", ovl_event, 1'b0);
        check_bit("R1", "cfg_invalid", cfg_invalid, 1'b0);
        rst_n = 1'b1;

        // R2, R3, R4, R5: sweep codes, trigger counts and patterns
        for (int code = 0; code < 7; code++) begin
            for (int ti = 0; ti < 6; ti++) begin
                int trig;
                int len;
                len = len_of(code);
                case (ti)
                    0: trig = 1;
                    1: trig = 2;
                    2: trig = 3;
                    3: trig = len;
                    4: trig = len + 1;
                    default: trig = 0;
                endcase
                for (int pat = 0; pat < 3; pat++) begin
                    for (int i = 0; i < 3 * len + 2; i++) begin
                        bit fl;
                        int mg;
                        fl = 1'b0; mg = 0;
                        case (pat)
                            0: fl = 1'b1;                               // R3 every sample overloads
                            1: mg = (i % 2 == 0) ? 101 : 100;           // R5 strict compare
                            default: fl = (i % 3 != 1);                 // R4 sparse overloads
                        endcase
                        if (ti >= 4) step("R9", 1'b1, code, trig, 1'b1, fl, mg);
                        else if (pat == 1) step("R5", 1'b1, code, trig, 1'b1, fl, mg);
                        else if (ti == 3) step("R4", 1'b1, code, trig, 1'b1, fl, mg);
                        else step("R2", 1'b1, code, trig, 1'b1, fl, mg);
                    end
                end
            end
        end

        // R6: gaps in sample_valid
        for (int code = 1; code < 7; code++) begin
            for (int i = 0; i < 4 * len_of(code); i++)
                step("R6", 1'b1, code, 2, (i % 5 != 4), 1'b1, 0);
        end

        // R7: disable mid-window restarts the window
        for (int i = 0; i < 5; i++) step("R7", 1'b1, 2, 3, 1'b1, (i == 0), 0);
        for (int i = 0; i < 4; i++) step("R7", 1'b0, 2, 3, 1'b1, 1'b1, 0);
        for (int i = 0; i < 20; i++) step("R7", 1'b1, 2, 3, 1'b1, (i % 2 == 0), 0);

        // R8: illegal code mid-window, then back to a legal one
        for (int i = 0; i < 3; i++) step("R8", 1'b1, 1, 2, 1'b1, 1'b1, 0);
        for (int i = 0; i < 6; i++) step("R8", 1'b1, 7, 1, 1'b1, 1'b1, 0);
        for (int i = 0; i < 12; i++) step("R8", 1'b1, 1, 2, 1'b1, 1'b1, 0);

        // R3: default configuration, single-sample events
        for (int i = 0; i < 16; i++) step("R3", 1'b1, 1, 1, 1'b1, (i == 5 || i == 6 || i == 13), 0);
        step("R3", 1'b1, 1, 1, 1'b0, 1'b0, 0);
        step("R3", 1'b1, 1, 1, 1'b0, 1'b0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule